// File: doc/BRIEF.md
# Per-Port Source Address Intrusion Monitor

This block watches the source address carried by every frame a multi-port repeater receives. Each port has two address registers. The first holds the last source address seen on that port. The second holds a preferred address that the host programs. When a frame arrives, its address is compared against both registers of its port. Two sticky status bits can then be raised: a changed-address flag and an intruder flag. Per-port enables turn these flags into interrupt outputs, and a single combined line ORs all of them.

A per-port lock can freeze the last-seen register against received frames. While locked, only the host can write that register. The host reaches every register through a small read/write strobe interface, using an address made of a register-kind field and a port field. An unlocked port keeps following its traffic, so the host can learn an unknown address by reading the last-seen register and then copying it into the preferred register.

The frame path is a two-state machine. MON_IDLE waits for a strobe. MON_EVAL compares the captured address against the register contents and commits the results at the end of that cycle. There are three transitions. T_ACCEPT goes from MON_IDLE to MON_EVAL on a strobe. T_CHAIN keeps the machine in MON_EVAL when another strobe arrives in the same cycle. T_DRAIN returns it to MON_IDLE when no strobe arrives.

Top module: `srcaddr_guard`

## Requirements
- R1: After reset, every last-seen and preferred register reads 0, all lock bits are 0, all enable bits are 0 (every interrupt masked), all status flags are 0 and `irq` is 0.
- R2: The host address is {kind[2:0], port}. The kinds are 0 last-seen, 1 preferred, 2 lock, 3 changed-enable, 4 intruder-enable, 5 changed-status, 6 intruder-status, and any other kind reads 0. A write to kind 0 or 1 sets that port's register to `hst_wdata`. A read returns the addressed value on `hst_rdata` one clock after `hst_rd` is sampled. For kinds 2 to 6, bit i of the data belongs to port i and the port field is ignored.
- R3: When a port is unlocked, a frame sampled at clock edge k sets that port's last-seen register to the frame address at edge k+1.
- R4: When a port's lock bit is 1, a received frame leaves its last-seen register unchanged, whether or not the address matches. A host write still changes that register.
- R5: A frame sets its port's changed flag when its address differs from both the last-seen and the preferred register. The flag is set at edge k+1.
- R6: A frame sets its port's intruder flag when its address differs from the preferred register. The flag is set at edge k+1.
- R7: Status flags stay set until the host writes 1 to the matching bit of kind 5 or 6. Writing 0 has no effect. If a set and a clear land on the same edge, the set wins.
- R8: `chg_irq[i]` equals the changed flag AND the changed-enable bit of port i. `intr_irq[i]` equals the intruder flag AND the intruder-enable bit of port i. `irq` is the OR of all bits of both vectors.
- R9: Each frame is compared against the register contents left by all earlier frames, including a frame strobed in the cycle just before it. It never sees its own update.
- R10: When a host write to a last-seen register and a frame update of the same register land on the same edge, the host value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | Received-frame source address strobe |
| frm_port | input | PORT_W | Port that received the frame |
| frm_srcaddr | input | ADDR_W | Source address of the frame |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_addr | input | 3+PORT_W | Host register address {kind, port} |
| hst_wdata | input | ADDR_W | Host write data |
| hst_rdata | output | ADDR_W | Host read data, valid one clock after the read strobe |
| chg_flag | output | NUM_PORTS | Sticky changed-address status per port |
| intr_flag | output | NUM_PORTS | Sticky intruder status per port |
| chg_irq | output | NUM_PORTS | Enabled changed-address interrupts |
| intr_irq | output | NUM_PORTS | Enabled intruder interrupts |
| irq | output | 1 | OR of all enabled interrupts |

## Verification
Results from a frame are due two edges after its strobe is first sampled: one edge into MON_EVAL and one edge to commit. Host writes take effect at the next edge, and read data is registered at the edge that samples `hst_rd`. The bench drives every input on the falling edge and samples outputs on the falling edge after the due edge. It then compares them against a bench-side model of both registers and both flags for each port, covering the lock, match and mask combinations. The same-edge collisions in R7, R9 and R10 are set up by placing the second stimulus exactly one falling edge after the frame strobe.

// File: rtl/srcaddr_guard_pkg.sv
package srcaddr_guard_pkg;
    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        SEL_LAST    = 3'd0,
        SEL_PREF    = 3'd1,
        SEL_LOCK    = 3'd2,
        SEL_CHG_EN  = 3'd3,
        SEL_INTR_EN = 3'd4,
        SEL_CHG_ST  = 3'd5,
        SEL_INTR_ST = 3'd6
    } sel_kind_e;

    typedef enum logic {
        MON_IDLE = 1'b0,
        MON_EVAL = 1'b1
    } mon_state_e;
endpackage

// File: rtl/srcaddr_guard_regs.sv
module srcaddr_guard_regs #(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 48,
    parameter int PORT_W    = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_last,
    input  logic                               wr_pref,
    input  logic [PORT_W-1:0]                  wr_port,
    input  logic [ADDR_W-1:0]                  wr_data,
    input  logic                               upd_en,
    input  logic [PORT_W-1:0]                  upd_port,
    input  logic [ADDR_W-1:0]                  upd_addr,
    output logic [NUM_PORTS-1:0][ADDR_W-1:0]   last_q,
    output logic [NUM_PORTS-1:0][ADDR_W-1:0]   pref_q
);
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        logic host_hit_last;
        logic host_hit_pref;
        logic frame_hit;

        assign host_hit_last = wr_last && (wr_port == PORT_W'(i));
        assign host_hit_pref = wr_pref && (wr_port == PORT_W'(i));
        assign frame_hit     = upd_en  && (upd_port == PORT_W'(i));

        // host write has priority over the frame update
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                last_q[i] <= '0;
            end else if (host_hit_last) begin
                last_q[i] <= wr_data;
            end else if (frame_hit) begin
                last_q[i] <= upd_addr;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pref_q[i] <= '0;
            end else if (host_hit_pref) begin
                pref_q[i] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/srcaddr_guard_fsm.sv
module srcaddr_guard_fsm
    import srcaddr_guard_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 48,
    parameter int PORT_W    = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               frm_valid,
    input  logic [PORT_W-1:0]                  frm_port,
    input  logic [ADDR_W-1:0]                  frm_addr,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]   last_q,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]   pref_q,
    input  logic [NUM_PORTS-1:0]               lock_q,
    output logic                               commit,
    output logic [PORT_W-1:0]                  cmt_port,
    output logic [ADDR_W-1:0]                  cmt_addr,
    output logic                               cmt_upd,
    output logic                               miss_last,
    output logic                               miss_pref
);
    mon_state_e        state_q;
    mon_state_e        state_d;
    logic              accept;
    logic [PORT_W-1:0] cap_port;
    logic [ADDR_W-1:0] cap_addr;

    assign accept = frm_valid && ({1'b0, frm_port} < (PORT_W+1)'(NUM_PORTS));

    // state register and frame capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= MON_IDLE;
            cap_port <= '0;
            cap_addr <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cap_port <= frm_port;
                cap_addr <= frm_addr;
            end
        end
    end

    // transitions: T_ACCEPT, T_CHAIN, T_DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MON_IDLE: state_d = accept ? MON_EVAL : MON_IDLE;
            MON_EVAL: state_d = accept ? MON_EVAL : MON_IDLE;
            default:  state_d = MON_IDLE;
        endcase
    end

    // outputs: compare against contents before this frame's own update
    always_comb begin
        commit    = 1'b0;
        cmt_upd   = 1'b0;
        miss_last = 1'b0;
        miss_pref = 1'b0;
        cmt_port  = cap_port;
        cmt_addr  = cap_addr;
        unique case (state_q)
            MON_IDLE: begin
                commit = 1'b0;
            end
            MON_EVAL: begin
                commit    = 1'b1;
                miss_last = (cap_addr != last_q[cap_port]);
                miss_pref = (cap_addr != pref_q[cap_port]);
                cmt_upd   = !lock_q[cap_port];
            end
            default: commit = 1'b0;
        endcase
    end
endmodule

// File: rtl/srcaddr_guard_status.sv
module srcaddr_guard_status #(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_lock,
    input  logic                 wr_chg_en,
    input  logic                 wr_intr_en,
    input  logic                 clr_chg,
    input  logic                 clr_intr,
    input  logic [NUM_PORTS-1:0] wr_bits,
    input  logic                 commit,
    input  logic [PORT_W-1:0]    cmt_port,
    input  logic                 miss_last,
    input  logic                 miss_pref,
    output logic [NUM_PORTS-1:0] lock_q,
    output logic [NUM_PORTS-1:0] chg_en,
    output logic [NUM_PORTS-1:0] intr_en,
    output logic [NUM_PORTS-1:0] chg_st,
    output logic [NUM_PORTS-1:0] intr_st,
    output logic [NUM_PORTS-1:0] chg_irq,
    output logic [NUM_PORTS-1:0] intr_irq,
    output logic                 irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q  <= '0;
            chg_en  <= '0;
            intr_en <= '0;
        end else begin
            if (wr_lock)    lock_q  <= wr_bits;
            if (wr_chg_en)  chg_en  <= wr_bits;
            if (wr_intr_en) intr_en <= wr_bits;
        end
    end

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_flag
        logic on_port;
        assign on_port = commit && (cmt_port == PORT_W'(i));

        // set beats clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chg_st[i] <= 1'b0;
            end else if (on_port && miss_last && miss_pref) begin
                chg_st[i] <= 1'b1;
            end else if (clr_chg && wr_bits[i]) begin
                chg_st[i] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                intr_st[i] <= 1'b0;
            end else if (on_port && miss_pref) begin
                intr_st[i] <= 1'b1;
            end else if (clr_intr && wr_bits[i]) begin
                intr_st[i] <= 1'b0;
            end
        end
    end

    assign chg_irq  = chg_st & chg_en;
    assign intr_irq = intr_st & intr_en;
    assign irq      = |{chg_irq, intr_irq};
endmodule

// File: rtl/srcaddr_guard.sv
module srcaddr_guard
    import srcaddr_guard_pkg::*;
#(
    parameter  int NUM_PORTS = 4,
    parameter  int ADDR_W    = 48,
    localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int HA_W      = KIND_W + PORT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frm_valid,
    input  logic [PORT_W-1:0]    frm_port,
    input  logic [ADDR_W-1:0]    frm_srcaddr,
    input  logic                 hst_wr,
    input  logic                 hst_rd,
    input  logic [HA_W-1:0]      hst_addr,
    input  logic [ADDR_W-1:0]    hst_wdata,
    output logic [ADDR_W-1:0]    hst_rdata,
    output logic [NUM_PORTS-1:0] chg_flag,
    output logic [NUM_PORTS-1:0] intr_flag,
    output logic [NUM_PORTS-1:0] chg_irq,
    output logic [NUM_PORTS-1:0] intr_irq,
    output logic                 irq
);
    logic [KIND_W-1:0]               hst_kind;
    logic [PORT_W-1:0]               hst_port;
    logic                            wr_last, wr_pref, wr_lock;
    logic                            wr_chg_en, wr_intr_en, clr_chg, clr_intr;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] last_q, pref_q;
    logic [NUM_PORTS-1:0]            lock_q, chg_en, intr_en;
    logic                            commit, cmt_upd, miss_last, miss_pref;
    logic [PORT_W-1:0]               cmt_port;
    logic [ADDR_W-1:0]               cmt_addr;

    assign hst_kind   = hst_addr[HA_W-1:PORT_W];
    assign hst_port   = hst_addr[PORT_W-1:0];
    assign wr_last    = hst_wr && (hst_kind == SEL_LAST);
    assign wr_pref    = hst_wr && (hst_kind == SEL_PREF);
    assign wr_lock    = hst_wr && (hst_kind == SEL_LOCK);
    assign wr_chg_en  = hst_wr && (hst_kind == SEL_CHG_EN);
    assign wr_intr_en = hst_wr && (hst_kind == SEL_INTR_EN);
    assign clr_chg    = hst_wr && (hst_kind == SEL_CHG_ST);
    assign clr_intr   = hst_wr && (hst_kind == SEL_INTR_ST);

    srcaddr_guard_regs #(
        .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .PORT_W(PORT_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_last  (wr_last),
        .wr_pref  (wr_pref),
        .wr_port  (hst_port),
        .wr_data  (hst_wdata),
        .upd_en   (commit && cmt_upd),
        .upd_port (cmt_port),
        .upd_addr (cmt_addr),
        .last_q   (last_q),
        .pref_q   (pref_q)
    );

    srcaddr_guard_fsm #(
        .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .PORT_W(PORT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_valid (frm_valid),
        .frm_port  (frm_port),
        .frm_addr  (frm_srcaddr),
        .last_q    (last_q),
        .pref_q    (pref_q),
        .lock_q    (lock_q),
        .commit    (commit),
        .cmt_port  (cmt_port),
        .cmt_addr  (cmt_addr),
        .cmt_upd   (cmt_upd),
        .miss_last (miss_last),
        .miss_pref (miss_pref)
    );

    srcaddr_guard_status #(
        .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_lock    (wr_lock),
        .wr_chg_en  (wr_chg_en),
        .wr_intr_en (wr_intr_en),
        .clr_chg    (clr_chg),
        .clr_intr   (clr_intr),
        .wr_bits    (hst_wdata[NUM_PORTS-1:0]),
        .commit     (commit),
        .cmt_port   (cmt_port),
        .miss_last  (miss_last),
        .miss_pref  (miss_pref),
        .lock_q     (lock_q),
        .chg_en     (chg_en),
        .intr_en    (intr_en),
        .chg_st     (chg_flag),
        .intr_st    (intr_flag),
        .chg_irq    (chg_irq),
        .intr_irq   (intr_irq),
        .irq        (irq)
    );

    // registered host read mux
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hst_rdata <= '0;
        end else if (hst_rd) begin
            case (hst_kind)
                SEL_LAST:    hst_rdata <= last_q[hst_port];
                SEL_PREF:    hst_rdata <= pref_q[hst_port];
                SEL_LOCK:    hst_rdata <= ADDR_W'(lock_q);
                SEL_CHG_EN:  hst_rdata <= ADDR_W'(chg_en);
                SEL_INTR_EN: hst_rdata <= ADDR_W'(intr_en);
                SEL_CHG_ST:  hst_rdata <= ADDR_W'(chg_flag);
                SEL_INTR_ST: hst_rdata <= ADDR_W'(intr_flag);
                default:     hst_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/srcaddr_guard_chk.sv
module srcaddr_guard_chk #(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 48,
    parameter int PORT_W    = 2
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               wr_last,
    input logic                               clr_chg,
    input logic [PORT_W-1:0]                  wr_port,
    input logic [ADDR_W-1:0]                  wr_data,
    input logic                               commit,
    input logic                               cmt_upd,
    input logic                               miss_pref,
    input logic [PORT_W-1:0]                  cmt_port,
    input logic [ADDR_W-1:0]                  cmt_addr,
    input logic [NUM_PORTS-1:0][ADDR_W-1:0]   last_q,
    input logic [NUM_PORTS-1:0]               lock_q,
    input logic [NUM_PORTS-1:0]               chg_en,
    input logic [NUM_PORTS-1:0]               chg_flag,
    input logic [NUM_PORTS-1:0]               intr_flag,
    input logic [NUM_PORTS-1:0]               chg_irq
);
    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && cmt_upd && !(wr_last && wr_port == cmt_port))
        |=> last_q[$past(cmt_port)] == $past(cmt_addr));

    assert_host_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && cmt_upd && wr_last && wr_port == cmt_port)
        |=> last_q[$past(wr_port)] == $past(wr_data));

    assert_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_irq & ~(chg_flag & chg_en)) == '0);

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
        assert_lock_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (lock_q[i] && !(wr_last && wr_port == PORT_W'(i)))
            |=> $stable(last_q[i]));

        assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (chg_flag[i] && !(clr_chg && wr_data[i])) |=> chg_flag[i]);

        assert_chg_implies_intr_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(chg_flag[i]) |-> intr_flag[i]);

        assert_intr_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(intr_flag[i]) |-> $past(commit && miss_pref && cmt_port == PORT_W'(i)));
    end
endmodule

bind srcaddr_guard srcaddr_guard_chk #(
    .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .PORT_W(PORT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_last   (wr_last),
    .clr_chg   (clr_chg),
    .wr_port   (hst_port),
    .wr_data   (hst_wdata),
    .commit    (commit),
    .cmt_upd   (cmt_upd),
    .miss_pref (miss_pref),
    .cmt_port  (cmt_port),
    .cmt_addr  (cmt_addr),
    .last_q    (last_q),
    .lock_q    (lock_q),
    .chg_en    (chg_en),
    .chg_flag  (chg_flag),
    .intr_flag (intr_flag),
    .chg_irq   (chg_irq)
);

// File: tb/srcaddr_guard_test.sv
`timescale 1ns/1ps
module srcaddr_guard_test;
    localparam int NP = 4;
    localparam int AW = 48;
    localparam int PW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frm_valid = 1'b0;
    logic [PW-1:0] frm_port = '0;
    logic [AW-1:0] frm_srcaddr = '0;
    logic          hst_wr = 1'b0;
    logic          hst_rd = 1'b0;
    logic [PW+2:0] hst_addr = '0;
    logic [AW-1:0] hst_wdata = '0;
    logic [AW-1:0] hst_rdata;
    logic [NP-1:0] chg_flag, intr_flag, chg_irq, intr_irq;
    logic          irq;

    int n_checks = 0;
    int n_fail   = 0;
    logic [AW-1:0] m_last [NP];
    logic [AW-1:0] m_pref [NP];
    logic [NP-1:0] m_chg, m_intr, m_lock;

    always #2.5 clk = ~clk;

    srcaddr_guard #(.NUM_PORTS(NP), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_port(frm_port),
        .frm_srcaddr(frm_srcaddr), .hst_wr(hst_wr), .hst_rd(hst_rd),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .chg_flag(chg_flag), .intr_flag(intr_flag), .chg_irq(chg_irq),
        .intr_irq(intr_irq), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [AW-1:0] act,
                         input logic [AW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input int kind, input int port, input logic [AW-1:0] d);
        hst_wr = 1'b1; hst_addr = {3'(kind), PW'(port)}; hst_wdata = d;
        @(negedge clk);
        hst_wr = 1'b0;
    endtask

    task automatic hread(input int kind, input int port, output logic [AW-1:0] d);
        hst_rd = 1'b1; hst_addr = {3'(kind), PW'(port)};
        @(negedge clk);
        hst_rd = 1'b0;
        d = hst_rdata;
    endtask

    // model update for one frame (pre-update comparison)
    task automatic model_frame(input int p, input logic [AW-1:0] a);
        if (a != m_last[p] && a != m_pref[p]) m_chg[p] = 1'b1;
        if (a != m_pref[p]) m_intr[p] = 1'b1;
        if (!m_lock[p]) m_last[p] = a;
    endtask

    task automatic frame(input int p, input logic [AW-1:0] a);
        frm_valid = 1'b1; frm_port = PW'(p); frm_srcaddr = a;
        @(negedge clk);
        frm_valid = 1'b0;
        @(negedge clk);
        model_frame(p, a);
    endtask

    task automatic clear_all();
        hwrite(5, 0, '1); hwrite(6, 0, '1);
        m_chg = '0; m_intr = '0;
    endtask

    function automatic logic [AW-1:0] pat(input int seed);
        return {16'(seed * 16'h9e37 + 16'h1234), 32'(seed * 32'h0101_0407)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [AW-1:0] rd;
        for (int i = 0; i < NP; i++) begin m_last[i] = '0; m_pref[i] = '0; end
        m_chg = '0; m_intr = '0; m_lock = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(irq == 1'b0 && chg_flag == '0 && intr_flag == '0, "R1 flags", AW'({irq, chg_flag, intr_flag}), '0);
        for (int k = 0; k < 7; k++) begin
            for (int p = 0; p < NP; p++) begin
                hread(k, p, rd);
                check(rd == '0, "R1 register", rd, '0);
            end
        end

        // R2 write/readback, kind 7 reads zero
        for (int p = 0; p < NP; p++) begin
            m_last[p] = pat(p + 1); m_pref[p] = pat(p + 40);
            hwrite(0, p, m_last[p]); hwrite(1, p, m_pref[p]);
        end
        for (int p = 0; p < NP; p++) begin
            hread(0, p, rd); check(rd == m_last[p], "R2 last", rd, m_last[p]);
            hread(1, p, rd); check(rd == m_pref[p], "R2 pref", rd, m_pref[p]);
        end
        hread(7, 0, rd); check(rd == '0, "R2 unused kind", rd, '0);

        // R3 R4 R5 R6 sweep: lock x port x address choice
        for (int lk = 0; lk < 2; lk++) begin
            m_lock = lk ? '1 : '0;
            hwrite(2, 0, AW'(m_lock));
            hread(2, 0, rd); check(rd == AW'(m_lock), "R4 lock readback", rd, AW'(m_lock));
            for (int p = 0; p < NP; p++) begin
                for (int c = 0; c < 4; c++) begin
                    logic [AW-1:0] a;
                    m_last[p] = pat(100 + p); m_pref[p] = (c == 3) ? pat(100 + p) : pat(200 + p);
                    hwrite(0, p, m_last[p]); hwrite(1, p, m_pref[p]);
                    clear_all();
                    a = (c == 0) ? m_last[p] : (c == 1) ? m_pref[p] : (c == 2) ? pat(300 + p + 8 * lk) : m_pref[p];
                    frame(p, a);
                    check(chg_flag == m_chg, "R5 changed flag", AW'(chg_flag), AW'(m_chg));
                    check(intr_flag == m_intr, "R6 intruder flag", AW'(intr_flag), AW'(m_intr));
                    hread(0, p, rd);
                    check(rd == m_last[p], lk ? "R4 locked last" : "R3 captured last", rd, m_last[p]);
                end
            end
            // R4 host write still changes locked register
            hwrite(0, 1, pat(77)); m_last[1] = pat(77);
            hread(0, 1, rd); check(rd == m_last[1], "R4 host write under lock", rd, m_last[1]);
        end
        m_lock = '0; hwrite(2, 0, '0);

        // R8 mask sweep with all flags set
        for (int p = 0; p < NP; p++) frame(p, pat(500 + p));
        check(chg_flag == '1 && intr_flag == '1, "R5 all set", AW'({chg_flag, intr_flag}), AW'({NP*2{1'b1}}));
        check(irq == 1'b0, "R8 all masked", AW'(irq), '0);
        for (int e = 0; e < 16; e++) begin
            hwrite(3, 0, AW'(e)); hwrite(4, 0, AW'(15 - e));
            check(chg_irq == NP'(e), "R8 chg mask", AW'(chg_irq), AW'(e));
            check(intr_irq == NP'(15 - e), "R8 intr mask", AW'(intr_irq), AW'(15 - e));
            check(irq == 1'b1, "R8 combined", AW'(irq), 1);
        end
        hwrite(4, 0, '0);
        hwrite(3, 0, AW'(4'b1000));

        // R7 partial clear and write-0 no effect
        hwrite(5, 0, AW'(4'b0110)); m_chg = 4'b1001;
        check(chg_flag == m_chg, "R7 partial clear", AW'(chg_flag), AW'(m_chg));
        hwrite(6, 0, '0);
        check(intr_flag == '1, "R7 zero write", AW'(intr_flag), AW'(4'hf));
        hwrite(5, 0, AW'(4'b1000)); m_chg = 4'b0001;
        check(irq == 1'b0 && chg_flag == m_chg, "R8 irq drops", AW'({irq, chg_flag}), AW'(m_chg));

        // R7 set wins over same-edge clear (port 2)
        clear_all();
        frm_valid = 1'b1; frm_port = 2'd2; frm_srcaddr = pat(900);
        @(negedge clk);
        frm_valid = 1'b0;
        hst_wr = 1'b1; hst_addr = {3'd5, 2'd0}; hst_wdata = AW'(4'b0100);
        @(negedge clk);
        hst_wr = 1'b0;
        model_frame(2, pat(900));
        check(chg_flag[2] == 1'b1, "R7 set wins", AW'(chg_flag), AW'(4'b0100));

        // R9 back-to-back on port 0: first matches pref, second equals the old last
        m_last[0] = pat(11); m_pref[0] = pat(12);
        hwrite(0, 0, m_last[0]); hwrite(1, 0, m_pref[0]);
        clear_all();
        frm_valid = 1'b1; frm_port = 2'd0; frm_srcaddr = pat(12);
        @(negedge clk);
        frm_srcaddr = pat(11);
        @(negedge clk);
        frm_valid = 1'b0;
        @(negedge clk);
        model_frame(0, pat(12)); model_frame(0, pat(11));
        check(chg_flag == m_chg && m_chg == 4'b0001, "R9 chained compare", AW'(chg_flag), AW'(m_chg));
        hread(0, 0, rd); check(rd == pat(11), "R9 final last", rd, pat(11));

        // R10 host write collides with frame update on port 3
        frm_valid = 1'b1; frm_port = 2'd3; frm_srcaddr = pat(600);
        @(negedge clk);
        frm_valid = 1'b0;
        hst_wr = 1'b1; hst_addr = {3'd0, 2'd3}; hst_wdata = pat(601);
        @(negedge clk);
        hst_wr = 1'b0;
        hread(0, 3, rd); check(rd == pat(601), "R10 host wins", rd, pat(601));

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule